// File: doc/BRIEF.md
# Interface Delay Calibration Sweep Controller

This block tunes the clock-delay and data-delay settings of a source-synchronous receive interface without software help. The far-end device sends a pseudorandom test pattern. A local sequence checker reports on a single `lock` line whether it is tracking that pattern. On a `start` pulse the controller runs two sweeps. It first steps the data delay through every setting while the clock delay stays at zero. It then steps the clock delay through every setting while the data delay stays at zero.

For each setting the controller writes a configuration word over a simple valid/ready register-write port. It then ignores `lock` for a programmable settling time, and after that requires `lock` to stay high for a programmable observation window. The controller records the longest contiguous run of passing settings in each sweep. The sweep with the wider run gets that run's midpoint, and the other delay stays at zero. The chosen pair is written back as a final word and shown on the result outputs.

One instance serves one direction. The receive instance uses the default register address 'h006. A transmit instance is given 'h007 through the `CFG_ADDR` parameter, and software runs it after the receive calibration has finished.

Top module: `dly_cal_sweep`

## Requirements
- R1: After `start` in idle, the block issues 16 writes to `CFG_ADDR` with the data field (bits [3:0]) stepping 0..15 and the clock field (bits [7:4]) at 0. It then issues 16 writes with the clock field stepping 0..15 and the data field at 0.
- R2: Once `wr_valid` is raised, it stays high with `wr_data` unchanged until a cycle in which `wr_ready` is also high. That cycle completes the write.
- R3: After each completed write, `lock` is ignored for `settle_cycles` cycles, so a drop in that interval has no effect. `lock` is then sampled for `obs_cycles` cycles (0 counts as 1). The setting passes only if `lock` was high on every sample.
- R4: Each sweep keeps its longest contiguous run of passing settings. When two runs have equal length, the earlier one is kept.
- R5: The chosen setting is the run start plus the run length divided by two, rounded down.
- R6: The final (33rd) write and the result carry the midpoint for the sweep with the longer run, with the other field at 0. When both runs have equal non-zero length, the data delay is the one chosen.
- R7: If neither sweep has a passing setting, `fail` goes high and the final write and both result outputs are 0.
- R8: `done` is high for exactly one cycle, in the cycle after the final write completes. `data_dly`, `clk_dly` and `fail` take their new values in that cycle and hold them until the next completion.
- R9: `busy` is high from the cycle after an accepted `start` until the `done` cycle, in which it is low. A `start` pulse while busy is ignored and does not disturb the write sequence.
- R10: After reset, `busy`, `done`, `fail` and `wr_valid` are low and both delay outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin calibration |
| settle_cycles | input | CNT_W | Cycles to ignore lock after each write |
| obs_cycles | input | CNT_W | Cycles lock must stay high (0 treated as 1) |
| lock | input | 1 | Pattern checker lock flag |
| wr_ready | input | 1 | Register-write port ready |
| wr_valid | output | 1 | Register-write request |
| wr_addr | output | ADDR_W | Register address (CFG_ADDR) |
| wr_data | output | 2*DLY_W | Clock field high, data field low |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No passing setting found |
| data_dly | output | DLY_W | Chosen data delay |
| clk_dly | output | DLY_W | Chosen clock delay |

## Verification
The in-module assertions check on every cycle the write-port hold rule and the zeroed off-axis field during each sweep. They also check that the recorded best run never shrinks within a run, that at least one result field is always zero, that a failed result is all zeros, and that `done` and `busy` never overlap. Only the bench scenarios show that the settle interval really masks early lock drops while the observation window catches late ones. The scenarios are also needed to confirm that run ties inside a sweep and between sweeps resolve as required and that the midpoint arithmetic is right. The bench holds the expected 33-write sequence and result for each lock pattern, which it computes from the pass masks. It compares every completed write, and the busy and done behaviour, clock by clock under both free and throttled `wr_ready`.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;

    localparam int NUM_AXES = 2;

    typedef enum logic {
        AX_DATA = 1'b0,
        AX_CLK  = 1'b1
    } axis_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DWELL,
        ST_DECIDE,
        ST_FINAL
    } cal_state_e;

    typedef enum logic [1:0] {
        DW_IDLE,
        DW_SETTLE,
        DW_OBSERVE
    } dwell_state_e;

endpackage

// File: rtl/dly_cal_wrport.sv
module dly_cal_wrport #(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h006
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fire
);

    assign wr_addr = CFG_ADDR;
    assign fire    = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else if (load) begin
            wr_valid <= 1'b1;
            wr_data  <= load_data;
        end else if (fire) begin
            wr_valid <= 1'b0;
        end
    end

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !wr_valid);

endmodule

// File: rtl/dly_cal_dwell.sv
module dly_cal_dwell
    import dly_cal_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [CNT_W-1:0] obs_cycles,
    input  logic             lock,
    output logic             step_done,
    output logic             step_pass
);

    dwell_state_e     phase;
    logic [CNT_W-1:0] cnt;
    logic             pass_acc;
    logic [CNT_W-1:0] obs_last;
    logic             settle_end;

    assign obs_last   = (obs_cycles == '0) ? '0 : obs_cycles - 1'b1;
    assign settle_end = ({1'b0, cnt} + 1'b1) >= {1'b0, settle_cycles};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= DW_IDLE;
            cnt       <= '0;
            pass_acc  <= 1'b0;
            step_done <= 1'b0;
            step_pass <= 1'b0;
        end else begin
            step_done <= 1'b0;
            case (phase)
                DW_IDLE: begin
                    if (arm) begin
                        phase <= DW_SETTLE;
                        cnt   <= '0;
                    end
                end
                DW_SETTLE: begin
                    if (settle_end) begin
                        phase    <= DW_OBSERVE;
                        cnt      <= '0;
                        pass_acc <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                DW_OBSERVE: begin
                    pass_acc <= pass_acc && lock;
                    if (cnt == obs_last) begin
                        phase     <= DW_IDLE;
                        step_done <= 1'b1;
                        step_pass <= pass_acc && lock;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= DW_IDLE;
            endcase
        end
    end

    // R3
    step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done);

    // R3
    dwell_arm_chk: assert property (@(posedge clk) disable iff (rst)
        arm |-> (phase == DW_IDLE));

endmodule

// File: rtl/dly_cal_window.sv
module dly_cal_window #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             step_pass,
    input  logic [DLY_W-1:0] step_idx,
    output logic [DLY_W:0]   best_len,
    output logic [DLY_W-1:0] mid_set
);

    localparam int LEN_W = DLY_W + 1;

    logic [DLY_W-1:0] cur_start;
    logic [LEN_W-1:0] cur_len;
    logic [DLY_W-1:0] best_start;
    logic [DLY_W-1:0] next_start;
    logic [LEN_W-1:0] next_len;
    logic [LEN_W-1:0] half_len;

    assign next_start = (cur_len == '0) ? step_idx : cur_start;
    assign next_len   = cur_len + 1'b1;
    assign half_len   = best_len >> 1;
    assign mid_set    = best_start + half_len[DLY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (step) begin
            if (step_pass) begin
                cur_start <= next_start;
                cur_len   <= next_len;
                if (next_len > best_len) begin
                    best_len   <= next_len;
                    best_start <= next_start;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    // R4
    win_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (best_len >= $past(best_len)));

    // R4
    win_run_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !step_pass) |=> (cur_len == '0));

endmodule

// File: rtl/dly_cal_sweep.sv
module dly_cal_sweep
    import dly_cal_pkg::*;
#(
    parameter int                DLY_W    = 4,
    parameter int                CNT_W    = 16,
    parameter int                ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h006
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CNT_W-1:0]     settle_cycles,
    input  logic [CNT_W-1:0]     obs_cycles,
    input  logic                 lock,
    input  logic                 wr_ready,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [2*DLY_W-1:0]   wr_data,
    output logic                 busy,
    output logic                 done,
    output logic                 fail,
    output logic [DLY_W-1:0]     data_dly,
    output logic [DLY_W-1:0]     clk_dly
);

    localparam int               DATA_W   = 2 * DLY_W;
    localparam int               LEN_W    = DLY_W + 1;
    localparam logic [DLY_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        logic [DLY_W-1:0] clk_set;
        logic [DLY_W-1:0] data_set;
    } dly_pair_t;

    cal_state_e       state;
    axis_e            axis;
    logic [DLY_W-1:0] idx;
    dly_pair_t        load_word;
    dly_pair_t        decide_word;
    dly_pair_t        pend_word;
    logic             decide_fail;
    logic             pend_fail;
    logic             load;
    logic             fire;
    logic             arm;
    logic             step_done;
    logic             step_pass;
    logic             clr;
    logic             last_step;

    logic [LEN_W-1:0] best_len [NUM_AXES];
    logic [DLY_W-1:0] mid_set  [NUM_AXES];

    assign busy      = (state != ST_IDLE);
    assign clr       = (state == ST_IDLE) && start;
    assign arm       = (state == ST_WRITE) && fire;
    assign last_step = (idx == LAST_IDX);

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            dly_cal_window #(.DLY_W(DLY_W)) u_window (
                .clk       (clk),
                .rst       (rst),
                .clr       (clr),
                .step      (step_done && (axis == axis_e'(a))),
                .step_pass (step_pass),
                .step_idx  (idx),
                .best_len  (best_len[a]),
                .mid_set   (mid_set[a])
            );
        end
    endgenerate

    dly_cal_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk           (clk),
        .rst           (rst),
        .arm           (arm),
        .settle_cycles (settle_cycles),
        .obs_cycles    (obs_cycles),
        .lock          (lock),
        .step_done     (step_done),
        .step_pass     (step_pass)
    );

    dly_cal_wrport #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_wrport (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_word),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fire      (fire)
    );

    // Result selection: wider window wins, data axis on a tie.
    always_comb begin
        decide_word = '0;
        decide_fail = 1'b0;
        if (best_len[AX_DATA] == '0 && best_len[AX_CLK] == '0) begin
            decide_fail = 1'b1;
        end else if (best_len[AX_DATA] >= best_len[AX_CLK]) begin
            decide_word.data_set = mid_set[AX_DATA];
        end else begin
            decide_word.clk_set = mid_set[AX_CLK];
        end
    end

    // Next word presented to the write port.
    always_comb begin
        load      = 1'b0;
        load_word = '0;
        case (state)
            ST_IDLE:   load = start;
            ST_DWELL: begin
                if (step_done) begin
                    if (!last_step) begin
                        load = 1'b1;
                        if (axis == AX_DATA) load_word.data_set = idx + 1'b1;
                        else                 load_word.clk_set  = idx + 1'b1;
                    end else if (axis == AX_DATA) begin
                        load = 1'b1;
                    end
                end
            end
            ST_DECIDE: begin
                load      = 1'b1;
                load_word = decide_word;
            end
            default: load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            axis      <= AX_DATA;
            idx       <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            data_dly  <= '0;
            clk_dly   <= '0;
            pend_word <= '0;
            pend_fail <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        axis  <= AX_DATA;
                        idx   <= '0;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (fire) state <= ST_DWELL;
                end
                ST_DWELL: begin
                    if (step_done) begin
                        if (!last_step) begin
                            idx   <= idx + 1'b1;
                            state <= ST_WRITE;
                        end else if (axis == AX_DATA) begin
                            axis  <= AX_CLK;
                            idx   <= '0;
                            state <= ST_WRITE;
                        end else begin
                            state <= ST_DECIDE;
                        end
                    end
                end
                ST_DECIDE: begin
                    pend_word <= decide_word;
                    pend_fail <= decide_fail;
                    state     <= ST_FINAL;
                end
                ST_FINAL: begin
                    if (fire) begin
                        done     <= 1'b1;
                        data_dly <= pend_word.data_set;
                        clk_dly  <= pend_word.clk_set;
                        fail     <= pend_fail;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    data_sweep_field_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && axis == AX_DATA) |-> (wr_data[DATA_W-1:DLY_W] == '0));

    // R1
    clk_sweep_field_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && axis == AX_CLK) |-> (wr_data[DLY_W-1:0] == '0));

    // R6
    one_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_dly == '0) || (data_dly == '0));

    // R7
    fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> (clk_dly == '0 && data_dly == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/dly_cal_sweep_tb.sv
module dly_cal_sweep_tb;

    localparam int DLY_W = 4;
    localparam int CNT_W = 16;
    localparam int ADDR_W = 10;
    localparam int NSET = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  settle_cycles = 16'd3;
    logic [CNT_W-1:0]  obs_cycles = 16'd8;
    logic              lock = 1'b0;
    logic              wr_ready = 1'b1;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              busy, done, fail;
    logic [DLY_W-1:0]  data_dly, clk_dly;

    always #10 clk = ~clk;

    dly_cal_sweep #(.DLY_W(DLY_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
        .obs_cycles(obs_cycles), .lock(lock), .wr_ready(wr_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .fail(fail), .data_dly(data_dly), .clk_dly(clk_dly)
    );

    int nchecks = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scenario description: per axis (0 data, 1 clock) and per setting.
    logic [15:0] pass_m [2];
    logic [15:0] late_m [2];
    logic [15:0] glitch_m [2];
    bit          bp_en = 1'b0;
    string       res_tag = "R5";

    logic [7:0]  exp_q [$];
    int          exp_data, exp_clk;
    bit          exp_fail;
    bit          run_active = 1'b0;
    int          wr_count = 0;
    int          k = 1000;
    int          cur_axis = 0;
    int          cur_set = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          final_prev = 1'b0;
    bit          held_prev = 1'b0;
    logic [7:0]  held_data;
    int          cycles = 0;

    task automatic best_run(input logic [15:0] m, output int bs, output int bl);
        int cs = 0;
        int cl = 0;
        bs = 0;
        bl = 0;
        for (int i = 0; i < NSET; i++) begin
            if (m[i]) begin
                if (cl == 0) cs = i;
                cl++;
                if (cl > bl) begin
                    bl = cl;
                    bs = cs;
                end
            end else begin
                cl = 0;
            end
        end
    endtask

    task automatic prepare();
        int ds, dl, cs, cl;
        exp_q.delete();
        for (int i = 0; i < NSET; i++) exp_q.push_back({4'd0, 4'(i)});
        for (int i = 0; i < NSET; i++) exp_q.push_back({4'(i), 4'd0});
        best_run(pass_m[0] & ~late_m[0], ds, dl);
        best_run(pass_m[1] & ~late_m[1], cs, cl);
        exp_data = 0;
        exp_clk  = 0;
        exp_fail = 1'b0;
        if (dl == 0 && cl == 0) exp_fail = 1'b1;
        else if (dl >= cl)      exp_data = ds + dl / 2;
        else                    exp_clk  = cs + cl / 2;
        exp_q.push_back({4'(exp_clk), 4'(exp_data)});
        wr_count = 0;
    endtask

    // Reference model and checker, acting away from the active edge.
    always @(negedge clk) begin
        if (bp_en) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_ready = lfsr[0] | lfsr[3];
        end else begin
            wr_ready = 1'b1;
        end
        k++;
        lock = pass_m[cur_axis][cur_set]
               && !(late_m[cur_axis][cur_set] && k >= 6)
               && !(glitch_m[cur_axis][cur_set] && k <= 2);
        if (run_active) begin
            if (final_prev) begin
                chk(done == 1'b1, "R8 done pulse", int'(done), 1);
                chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
                chk(int'(data_dly) == exp_data, {res_tag, " data_dly"}, int'(data_dly), exp_data);
                chk(int'(clk_dly) == exp_clk, {res_tag, " clk_dly"}, int'(clk_dly), exp_clk);
                chk(fail == exp_fail, "R7 fail flag", int'(fail), int'(exp_fail));
                run_active = 1'b0;
            end else begin
                chk(busy == 1'b1, "R9 busy during run", int'(busy), 1);
                chk(done == 1'b0, "R8 no early done", int'(done), 0);
            end
            if (held_prev)
                chk(wr_valid && wr_data == held_data, "R2 held write",
                    int'(wr_data), int'(held_data));
        end
        final_prev = 1'b0;
        held_prev  = 1'b0;
        if (run_active && wr_valid) begin
            if (wr_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected extra write", int'(wr_data), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    wr_count++;
                    if (wr_count <= 32)
                        chk(wr_data == e, "R1 sweep write", int'(wr_data), int'(e));
                    else
                        chk(wr_data == e, exp_fail ? "R7 final write" : "R6 final write",
                            int'(wr_data), int'(e));
                    chk(wr_addr == 10'h006, "R1 write address", int'(wr_addr), 6);
                    if (wr_count <= 32) begin
                        cur_axis = (wr_count - 1) / NSET;
                        cur_set  = (wr_count - 1) % NSET;
                    end
                    k = 0;
                    if (exp_q.size() == 0) final_prev = 1'b1;
                end
            end else begin
                held_prev = 1'b1;
                held_data = wr_data;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    task automatic run_cal(input bit poke_start);
        prepare();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0; run_active = 1'b1;
        if (poke_start) begin
            // R9: a second start while busy must not restart the sequence
            wait (wr_count == 10);
            @(posedge clk); #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        wait (!run_active);
        repeat (4) @(negedge clk);
        chk(int'(data_dly) == exp_data && int'(clk_dly) == exp_clk && !busy,
            "R8 result held", int'(data_dly), exp_data);
        chk(exp_q.size() == 0, "R1 write count", 33 - exp_q.size(), 33);
    endtask

    initial begin
        for (int a = 0; a < 2; a++) begin
            pass_m[a] = '0; late_m[a] = '0; glitch_m[a] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !fail && !wr_valid, "R10 reset flags",
            int'({busy, done, fail, wr_valid}), 0);
        chk(data_dly == 0 && clk_dly == 0, "R10 reset delays",
            int'({clk_dly, data_dly}), 0);

        // Data window 3..8 beats clock window 10..12 (R5 midpoint 6).
        pass_m[0] = 16'h01F8; pass_m[1] = 16'h1C00;
        settle_cycles = 16'd3; obs_cycles = 16'd8; res_tag = "R5";
        run_cal(1'b1);

        // R3: late drop at clock setting 3 splits the run; early glitch at 8 is masked.
        pass_m[0] = 16'h03E6; pass_m[1] = 16'hFFFF;
        late_m[1] = 16'h0008; glitch_m[1] = 16'h0100;
        bp_en = 1'b1; res_tag = "R3";
        run_cal(1'b0);
        late_m[1] = '0; glitch_m[1] = '0; bp_en = 1'b0;

        // R4 equal runs in the data sweep keep the earlier; R6 equal widths pick data.
        pass_m[0] = 16'h0F0F; pass_m[1] = 16'hF000; res_tag = "R4";
        run_cal(1'b0);

        // R6 window at the top edge, zero settle and zero observe.
        pass_m[0] = 16'hE000; pass_m[1] = 16'h0000;
        settle_cycles = 16'd0; obs_cycles = 16'd0; res_tag = "R6";
        run_cal(1'b0);

        // R7 no passing setting anywhere.
        pass_m[0] = 16'h0000; pass_m[1] = 16'h0000;
        settle_cycles = 16'd2; obs_cycles = 16'd3; res_tag = "R7";
        run_cal(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule